// File: doc/BRIEF.md
# Instruction Cache Line Refill Master

This block is the read-only bus master that fills instruction cache lines from memory over an AXI4 read channel. Two sources feed it. Cache misses bring the line address and a request tag. A streaming prefetcher offers lines ahead of demand with the same fields. A miss always wins over a prefetch offered in the same cycle. Each accepted request becomes one line-aligned read on the address channel.

Returned beats are passed on in request order. Each beat carries the tag of its request, a prefetch marker and a marker for the final word of the line. An in-order tag queue tracks the requests that are still open. A beat counter checks that the slave's last-beat flag arrives on the beat where it is expected. Any mismatch, or any beat that arrives while no request is open, sets a sticky error.

On a 32-bit bus a line takes a burst of 4, 8 or 16 beats. On a 128-, 256- or 512-bit bus the line fits in one beat. When caching of the range is optional and the cache-enable status is cleared, misses are not issued by this port. They are handed to the peripheral port unchanged.

Top module: `icache_refill_master`

## Requirements
- R1: After reset, `ar_valid`, `out_valid` and `err` are 0, and `byp_valid` is 0 while no miss is offered.
- R2: Every read address is the request address with the low log2(line bytes) bits cleared. `ar_len` is beats-per-line minus 1, `ar_size` is log2(bus bytes), and `ar_burst` is 2'b01 (incrementing). The address is held stable until `ar_ready`.
- R3: A request counts as open from its acceptance until its final beat is accepted. The limit on open requests is 1 on a bus wider than 32 bits. On a 32-bit bus it is 5 when streaming prefetch is enabled and 2 when it is not. At the limit, `miss_ready` and `pf_ready` are 0 on the cache path.
- R4: While `miss_valid` is 1 on the cache path, `pf_ready` is 0, so a miss is issued before a pending prefetch.
- R5: Each beat accepted with `r_valid` appears on `out_*` in the following cycle. `out_data` equals `r_data`, and `out_id` and `out_pf` belong to the oldest open request (`out_pf` 1 means a prefetch).
- R6: On a 32-bit bus, `out_last` is 1 exactly on the beats-per-line-th beat of each request.
- R7: `err` becomes 1 in the cycle after a beat whose `r_last` disagrees with the expected final beat, or after a beat that arrives with no request open. Once set, it stays 1 until reset.
- R8: With ALWAYS_USED = 0 and `cache_en` = 0, a miss is passed combinationally to the peripheral port. `byp_valid`/`byp_addr`/`byp_id` follow the `miss_*` inputs, and `miss_ready` follows `byp_ready`. No read is issued for it, and `pf_ready` is 0.
- R9: With ALWAYS_USED = 1, `cache_en` has no effect. Misses go to the read channel and `byp_valid` stays 0.
- R10: On a bus wider than 32 bits, each line is a single beat with `ar_len` = 0, and that beat carries `out_last` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Cache-enable status bit |
| miss_valid | input | 1 | Miss request offered |
| miss_ready | output | 1 | Miss request taken |
| miss_addr | input | ADDR_W | Miss fetch address |
| miss_id | input | ID_W | Miss request tag |
| pf_valid | input | 1 | Prefetch request offered |
| pf_ready | output | 1 | Prefetch request taken |
| pf_addr | input | ADDR_W | Prefetch line address |
| pf_id | input | ID_W | Prefetch request tag |
| byp_valid | output | 1 | Miss diverted to peripheral port |
| byp_ready | input | 1 | Peripheral port accepts |
| byp_addr | output | ADDR_W | Diverted address |
| byp_id | output | ID_W | Diverted tag |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address accepted |
| ar_addr | output | ADDR_W | Line-aligned read address |
| ar_len | output | 8 | Burst length minus 1 |
| ar_size | output | 3 | Log2 of bytes per beat |
| ar_burst | output | 2 | Burst type, incrementing |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data accepted (always 1) |
| r_data | input | BUS_W | Read data |
| r_last | input | 1 | Slave last-beat flag |
| out_valid | output | 1 | Line word valid |
| out_data | output | BUS_W | Line word |
| out_id | output | ID_W | Tag of owning request |
| out_last | output | 1 | Final word of line |
| out_pf | output | 1 | Word belongs to a prefetch |
| err | output | 1 | Sticky beat-sequence error |

## Verification
The bench builds two instances. The first has a 32-bit bus, 8-word lines, streaming prefetch on and ALWAYS_USED = 0. Long stalls of the read data let that instance fill all five open slots, and clearing `cache_en` makes misses take the peripheral bypass. The second has a 128-bit bus, 4-word lines and ALWAYS_USED = 1. It covers the single-beat line, the one-request limit even with streaming enabled, the case where `cache_en` does not divert, and a wrong last flag on a one-beat line.

// File: rtl/icr_pkg.sv
package icr_pkg;

    localparam logic [1:0] BURST_INCR = 2'b01;

    // Beats per line: a wide bus carries a whole line in one beat.
    function automatic int beats_per_line(input int bus_w, input int line_words);
        return (bus_w > 32) ? 1 : line_words;
    endfunction

    // Limit on open read requests for the configured mode.
    function automatic int read_limit(input int bus_w, input bit stream);
        if (bus_w > 32) return 1;
        return stream ? 5 : 2;
    endfunction

    // Tag queue depth: power of two at or above the limit, never below 2.
    function automatic int track_depth(input int bus_w, input bit stream);
        if (bus_w > 32 || !stream) return 2;
        return 8;
    endfunction

endpackage

// File: rtl/icr_route.sv
module icr_route #(
    parameter int ADDR_W      = 32,
    parameter int ID_W        = 3,
    parameter bit ALWAYS_USED = 1'b0,
    parameter bit STREAM_PF   = 1'b1
) (
    input  logic              cache_en,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [ID_W-1:0]   miss_id,
    output logic              miss_ready,
    input  logic              pf_valid,
    input  logic [ADDR_W-1:0] pf_addr,
    input  logic [ID_W-1:0]   pf_id,
    output logic              pf_ready,
    output logic              byp_valid,
    output logic [ADDR_W-1:0] byp_addr,
    output logic [ID_W-1:0]   byp_id,
    input  logic              byp_ready,
    input  logic              can_issue,
    output logic              issue,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [ID_W-1:0]   iss_id,
    output logic              iss_pf
);

    logic divert;
    logic take_miss;
    logic take_pf;

    always_comb begin
        divert     = !ALWAYS_USED && !cache_en;
        byp_valid  = divert && miss_valid;
        byp_addr   = miss_addr;
        byp_id     = miss_id;
        miss_ready = divert ? byp_ready : can_issue;
        pf_ready   = STREAM_PF && !divert && !miss_valid && can_issue;
        take_miss  = !divert && miss_valid && can_issue;
        take_pf    = pf_ready && pf_valid;
        issue      = take_miss || take_pf;
        iss_addr   = take_miss ? miss_addr : pf_addr;
        iss_id     = take_miss ? miss_id   : pf_id;
        iss_pf     = !take_miss;
    end

    always_comb begin
        AST_ROUTE_EXCLUSIVE: assert (!(byp_valid && issue)); // R8
    end

endmodule

// File: rtl/icr_tagq.sv
module icr_tagq #(
    parameter int W     = 4,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } tq_t;

    tq_t tq_q, tq_d;

    always_comb begin
        tq_d = tq_q;
        if (push) begin
            tq_d.mem[tq_q.wp] = push_data;
            tq_d.wp = (tq_q.wp == PTR_W'(DEPTH - 1)) ? '0 : tq_q.wp + 1'b1;
        end
        if (pop) begin
            tq_d.rp = (tq_q.rp == PTR_W'(DEPTH - 1)) ? '0 : tq_q.rp + 1'b1;
        end
        case ({push, pop})
            2'b10:   tq_d.cnt = tq_q.cnt + 1'b1;
            2'b01:   tq_d.cnt = tq_q.cnt - 1'b1;
            default: tq_d.cnt = tq_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tq_q <= '0;
        else        tq_q <= tq_d;
    end

    assign head  = tq_q.mem[tq_q.rp];
    assign count = tq_q.cnt;

    AST_TAGQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |-> tq_q.cnt < CNT_W'(DEPTH)); // R3
    AST_TAGQ_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> tq_q.cnt != '0); // R5

endmodule

// File: rtl/icr_ar.sv
module icr_ar #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic              ar_ready,
    output logic              ar_valid,
    output logic [ADDR_W-1:0] ar_addr,
    output logic              slot_free
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } ar_t;

    ar_t ar_q, ar_d;

    always_comb begin
        ar_d = ar_q;
        if (ar_q.vld && ar_ready) ar_d.vld = 1'b0;
        if (issue) begin
            ar_d.vld  = 1'b1;
            ar_d.addr = {iss_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ar_q <= '0;
        else        ar_q <= ar_d;
    end

    assign ar_valid  = ar_q.vld;
    assign ar_addr   = ar_q.addr;
    assign slot_free = !ar_q.vld;

    AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr)); // R2
    AST_AR_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !ar_valid); // R3

endmodule

// File: rtl/icr_beat.sv
module icr_beat #(
    parameter int BUS_W = 32,
    parameter int ID_W  = 3,
    parameter int BEATS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             r_valid,
    input  logic [BUS_W-1:0] r_data,
    input  logic             r_last,
    input  logic             q_empty,
    input  logic [ID_W-1:0]  head_id,
    input  logic             head_pf,
    output logic             pop,
    output logic             out_valid,
    output logic [BUS_W-1:0] out_data,
    output logic [ID_W-1:0]  out_id,
    output logic             out_last,
    output logic             out_pf,
    output logic             err
);

    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

    typedef struct packed {
        logic [BEAT_W-1:0] beat;
        logic              vld;
        logic [BUS_W-1:0]  data;
        logic [ID_W-1:0]   id;
        logic              last;
        logic              pf;
        logic              err;
    } bt_t;

    bt_t bt_q, bt_d;
    logic exp_last;

    always_comb begin
        bt_d     = bt_q;
        bt_d.vld = 1'b0;
        pop      = 1'b0;
        exp_last = (bt_q.beat == BEAT_W'(BEATS - 1));
        if (r_valid) begin
            if (q_empty) begin
                bt_d.err = 1'b1;
            end else begin
                bt_d.vld  = 1'b1;
                bt_d.data = r_data;
                bt_d.id   = head_id;
                bt_d.pf   = head_pf;
                bt_d.last = exp_last;
                if (r_last != exp_last) bt_d.err = 1'b1;
                if (exp_last) begin
                    bt_d.beat = '0;
                    pop       = 1'b1;
                end else begin
                    bt_d.beat = bt_q.beat + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bt_q <= '0;
        else        bt_q <= bt_d;
    end

    assign out_valid = bt_q.vld;
    assign out_data  = bt_q.data;
    assign out_id    = bt_q.id;
    assign out_last  = bt_q.last;
    assign out_pf    = bt_q.pf;
    assign err       = bt_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R7
    AST_EMPTY_BEAT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid && q_empty |=> err); // R7
    AST_OUT_FOLLOWS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid && !q_empty |=> out_valid && out_data == $past(r_data)); // R5

endmodule

// File: rtl/icache_refill_master.sv
module icache_refill_master
    import icr_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BUS_W       = 32,
    parameter int LINE_WORDS  = 8,
    parameter int ID_W        = 3,
    parameter bit STREAM_PF   = 1'b1,
    parameter bit ALWAYS_USED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [ID_W-1:0]   miss_id,
    input  logic              pf_valid,
    output logic              pf_ready,
    input  logic [ADDR_W-1:0] pf_addr,
    input  logic [ID_W-1:0]   pf_id,
    output logic              byp_valid,
    input  logic              byp_ready,
    output logic [ADDR_W-1:0] byp_addr,
    output logic [ID_W-1:0]   byp_id,
    output logic              ar_valid,
    input  logic              ar_ready,
    output logic [ADDR_W-1:0] ar_addr,
    output logic [7:0]        ar_len,
    output logic [2:0]        ar_size,
    output logic [1:0]        ar_burst,
    input  logic              r_valid,
    output logic              r_ready,
    input  logic [BUS_W-1:0]  r_data,
    input  logic              r_last,
    output logic              out_valid,
    output logic [BUS_W-1:0]  out_data,
    output logic [ID_W-1:0]   out_id,
    output logic              out_last,
    output logic              out_pf,
    output logic              err
);

    localparam int BEATS     = beats_per_line(BUS_W, LINE_WORDS);
    localparam int MAX_OUT   = read_limit(BUS_W, STREAM_PF);
    localparam int TQ_DEPTH  = track_depth(BUS_W, STREAM_PF);
    localparam int CNT_W     = $clog2(TQ_DEPTH + 1);
    localparam int OFF_W     = $clog2(LINE_WORDS * 4);
    localparam int SIZE_LOG  = $clog2(BUS_W / 8);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_OUT);

    logic              can_issue;
    logic              issue;
    logic [ADDR_W-1:0] iss_addr;
    logic [ID_W-1:0]   iss_id;
    logic              iss_pf;
    logic              slot_free;
    logic              pop;
    logic [ID_W:0]     head;
    logic [CNT_W-1:0]  tq_count;

    assign can_issue = slot_free && (tq_count < MAX_CNT);
    assign ar_len    = 8'(BEATS - 1);
    assign ar_size   = 3'(SIZE_LOG);
    assign ar_burst  = BURST_INCR;
    assign r_ready   = 1'b1;

    icr_route #(
        .ADDR_W(ADDR_W), .ID_W(ID_W),
        .ALWAYS_USED(ALWAYS_USED), .STREAM_PF(STREAM_PF)
    ) u_route (
        .cache_en  (cache_en),
        .miss_valid(miss_valid),
        .miss_addr (miss_addr),
        .miss_id   (miss_id),
        .miss_ready(miss_ready),
        .pf_valid  (pf_valid),
        .pf_addr   (pf_addr),
        .pf_id     (pf_id),
        .pf_ready  (pf_ready),
        .byp_valid (byp_valid),
        .byp_addr  (byp_addr),
        .byp_id    (byp_id),
        .byp_ready (byp_ready),
        .can_issue (can_issue),
        .issue     (issue),
        .iss_addr  (iss_addr),
        .iss_id    (iss_id),
        .iss_pf    (iss_pf)
    );

    icr_ar #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ar (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue),
        .iss_addr (iss_addr),
        .ar_ready (ar_ready),
        .ar_valid (ar_valid),
        .ar_addr  (ar_addr),
        .slot_free(slot_free)
    );

    icr_tagq #(.W(ID_W + 1), .DEPTH(TQ_DEPTH)) u_tagq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (issue),
        .push_data({iss_id, iss_pf}),
        .pop      (pop),
        .head     (head),
        .count    (tq_count)
    );

    icr_beat #(.BUS_W(BUS_W), .ID_W(ID_W), .BEATS(BEATS)) u_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .r_valid  (r_valid),
        .r_data   (r_data),
        .r_last   (r_last),
        .q_empty  (tq_count == '0),
        .head_id  (head[ID_W:1]),
        .head_pf  (head[0]),
        .pop      (pop),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_id   (out_id),
        .out_last (out_last),
        .out_pf   (out_pf),
        .err      (err)
    );

    AST_OPEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        tq_count <= MAX_CNT); // R3
    AST_WIDE_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (BEATS == 1) && out_valid |-> out_last); // R10

endmodule

// File: tb/tb_icache_refill_master.sv
module tb_icache_refill_master;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] dfn(input logic [31:0] a, input int b);
        return (a + 32'(b) * 4) ^ 32'hC3A5_0000;
    endfunction

    function automatic logic [31:0] align32(input logic [31:0] a);
        return a & ~32'h1F;
    endfunction

    // narrow instance
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b1;
    logic        miss_valid = 0, miss_ready, pf_valid = 0, pf_ready;
    logic [31:0] miss_addr = 0, pf_addr = 0, byp_addr, ar_addr;
    logic [2:0]  miss_id = 0, pf_id = 0, byp_id, out_id;
    logic        byp_valid, byp_ready = 0, ar_valid, ar_ready = 0;
    logic [7:0]  ar_len;
    logic [2:0]  ar_size;
    logic [1:0]  ar_burst;
    logic        r_valid = 0, r_ready, r_last = 0;
    logic [31:0] r_data = 0, out_data;
    logic        out_valid, out_last, out_pf, err;

    icache_refill_master #(.ADDR_W(32), .BUS_W(32), .LINE_WORDS(8), .ID_W(3),
                           .STREAM_PF(1'b1), .ALWAYS_USED(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr), .miss_id(miss_id),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_id(pf_id),
        .byp_valid(byp_valid), .byp_ready(byp_ready), .byp_addr(byp_addr), .byp_id(byp_id),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
        .ar_size(ar_size), .ar_burst(ar_burst),
        .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_last(r_last),
        .out_valid(out_valid), .out_data(out_data), .out_id(out_id), .out_last(out_last),
        .out_pf(out_pf), .err(err)
    );

    // wide instance
    logic         w_miss_valid = 0, w_miss_ready, w_pf_ready, w_byp_valid, w_ar_valid, w_ar_ready = 0;
    logic [31:0]  w_miss_addr = 0, w_byp_addr, w_ar_addr;
    logic [2:0]   w_miss_id = 0, w_byp_id, w_out_id;
    logic [7:0]   w_ar_len;
    logic [2:0]   w_ar_size;
    logic [1:0]   w_ar_burst;
    logic         w_r_valid = 0, w_r_ready, w_r_last = 0;
    logic [127:0] w_r_data = 0, w_out_data;
    logic         w_out_valid, w_out_last, w_out_pf, w_err;

    icache_refill_master #(.ADDR_W(32), .BUS_W(128), .LINE_WORDS(4), .ID_W(3),
                           .STREAM_PF(1'b1), .ALWAYS_USED(1'b1)) dut_w (
        .clk(clk), .rst_n(rst_n), .cache_en(1'b0),
        .miss_valid(w_miss_valid), .miss_ready(w_miss_ready), .miss_addr(w_miss_addr), .miss_id(w_miss_id),
        .pf_valid(1'b0), .pf_ready(w_pf_ready), .pf_addr(32'h0), .pf_id(3'h0),
        .byp_valid(w_byp_valid), .byp_ready(1'b1), .byp_addr(w_byp_addr), .byp_id(w_byp_id),
        .ar_valid(w_ar_valid), .ar_ready(w_ar_ready), .ar_addr(w_ar_addr), .ar_len(w_ar_len),
        .ar_size(w_ar_size), .ar_burst(w_ar_burst),
        .r_valid(w_r_valid), .r_ready(w_r_ready), .r_data(w_r_data), .r_last(w_r_last),
        .out_valid(w_out_valid), .out_data(w_out_data), .out_id(w_out_id), .out_last(w_out_last),
        .out_pf(w_out_pf), .err(w_err)
    );

    // bench model state
    logic [31:0] arq[$];
    logic [31:0] slq[$];
    logic [31:0] eq_addr[$];
    logic [2:0]  eq_id[$];
    logic        eq_pf[$];
    int  sb = 0, ob = 0, outst = 0, maxo = 0, cyc = 0, phase = 0;
    bit  run = 0, inject = 0, inj_now = 0, miss_taken = 0, pf_taken = 0, r_en = 0;
    bit  done = 0;

    always begin
        @(posedge clk);
        if (run) begin
            #1;
            cyc++;
            cache_en = (phase != 2);
            if (phase == 1 || phase == 2) begin
                if (!(miss_valid && !miss_taken)) begin
                    miss_valid = ($urandom % 3 == 0);
                    miss_addr  = $urandom;
                    miss_id    = 3'($urandom);
                end
                if (!(pf_valid && !pf_taken)) begin
                    pf_valid = ($urandom % 3 == 0);
                    pf_addr  = $urandom;
                    pf_id    = 3'($urandom);
                end
            end else begin
                miss_valid = 0;
                pf_valid   = 0;
            end
            byp_ready = 1'($urandom % 2);
            ar_ready  = ($urandom % 4 != 0);
            r_en      = (phase == 1) ? ((cyc % 300) >= 120) : 1'b1;
            inj_now   = inject;
            if (inject) begin
                inject  = 0;
                r_valid = 1;
                r_last  = 1;
                r_data  = 32'hDEAD_BEEF;
            end else begin
                r_valid = (slq.size() > 0) && r_en && ($urandom % 4 != 0);
                r_data  = (slq.size() > 0) ? dfn(slq[0], sb) : 32'h0;
                r_last  = (sb == 7);
            end

            @(negedge clk);
            miss_taken = miss_valid && miss_ready;
            pf_taken   = pf_valid && pf_ready;
            if (!cache_en) begin
                chk(byp_valid == miss_valid, "R8 byp_valid", byp_valid, miss_valid);
                chk(pf_ready == 0, "R8 pf_ready", pf_ready, 0);
                if (miss_valid) begin
                    chk(byp_addr == miss_addr && byp_id == miss_id, "R8 byp fields", byp_addr, miss_addr);
                    chk(miss_ready == byp_ready, "R8 miss_ready", miss_ready, byp_ready);
                end
            end else begin
                chk(byp_valid == 0, "R8 no bypass when enabled", byp_valid, 0);
                if (miss_valid) chk(pf_ready == 0, "R4 miss priority", pf_ready, 0);
                if (outst >= 5) chk(!miss_ready && !pf_ready, "R3 stall at limit", {miss_ready, pf_ready}, 0);
                if (miss_taken || pf_taken) chk(outst < 5, "R3 accept below limit", outst, 5);
            end
            if (ar_valid && ar_ready) begin
                if (arq.size() == 0) begin
                    chk(0, "R2 unexpected read", ar_addr, 0);
                end else begin
                    chk(ar_addr == align32(arq[0]), "R2 ar_addr", ar_addr, align32(arq[0]));
                    chk(ar_len == 8'd7 && ar_size == 3'd2 && ar_burst == 2'b01, "R2 ar fields",
                        {ar_len, ar_size, ar_burst}, {8'd7, 3'd2, 2'b01});
                    slq.push_back(ar_addr);
                    void'(arq.pop_front());
                end
            end
            if (cache_en && miss_taken) begin
                arq.push_back(miss_addr);
                eq_addr.push_back(miss_addr); eq_id.push_back(miss_id); eq_pf.push_back(0);
                outst++;
            end else if (cache_en && pf_taken) begin
                arq.push_back(pf_addr);
                eq_addr.push_back(pf_addr); eq_id.push_back(pf_id); eq_pf.push_back(1);
                outst++;
            end
            if (r_valid && !inj_now && slq.size() > 0) begin
                if (sb == 7) begin
                    sb = 0;
                    void'(slq.pop_front());
                    outst--;
                end else begin
                    sb++;
                end
            end
            if (outst > maxo) maxo = outst;
            if (out_valid) begin
                if (eq_addr.size() == 0) begin
                    chk(0, "R5 unexpected out beat", out_data, 0);
                end else begin
                    chk(out_data == dfn(align32(eq_addr[0]), ob), "R5 out_data", out_data,
                        dfn(align32(eq_addr[0]), ob));
                    chk(out_id == eq_id[0] && out_pf == eq_pf[0], "R5 out tag",
                        {out_id, out_pf}, {eq_id[0], eq_pf[0]});
                    chk(out_last == (ob == 7), "R6 out_last", out_last, (ob == 7));
                    if (ob == 7) begin
                        ob = 0;
                        void'(eq_addr.pop_front()); void'(eq_id.pop_front()); void'(eq_pf.pop_front());
                    end else begin
                        ob++;
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'h1CAC_4E11));
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(ar_valid == 0 && out_valid == 0 && err == 0, "R1 reset narrow",
            {ar_valid, out_valid, err}, 0);
        chk(byp_valid == 0, "R1 reset bypass", byp_valid, 0);
        chk(w_ar_valid == 0 && w_out_valid == 0 && w_err == 0, "R1 reset wide",
            {w_ar_valid, w_out_valid, w_err}, 0);
        chk(r_ready == 1, "R5 r_ready", r_ready, 1);
        #1 phase = 1;
        run = 1;
        repeat (4000) @(posedge clk);
        #2 phase = 2;
        repeat (800) @(posedge clk);
        #2 phase = 3;
        n = 0;
        while ((eq_addr.size() != 0 || slq.size() != 0 || arq.size() != 0) && n < 3000) begin
            @(posedge clk);
            n++;
        end
        repeat (4) @(posedge clk);
        #2;
        chk(eq_addr.size() == 0 && outst == 0, "R5 all lines delivered", eq_addr.size(), 0);
        chk(maxo == 5, "R3 five open reached", maxo, 5);
        chk(err == 0, "R7 no false error", err, 0);
        inject = 1;
        repeat (4) @(posedge clk);
        #2 chk(err == 1, "R7 beat with none open", err, 1);
        repeat (3) @(posedge clk);
        #2 chk(err == 1, "R7 sticky", err, 1);

        // wide instance, directed
        @(posedge clk); #1;
        w_miss_valid = 1; w_miss_addr = 32'h1234_5678; w_miss_id = 3'd5;
        @(negedge clk);
        chk(w_miss_ready == 1, "R9 cache_en ignored", w_miss_ready, 1);
        chk(w_byp_valid == 0, "R9 no bypass", w_byp_valid, 0);
        @(posedge clk); #1;
        w_miss_addr = 32'h2000_0040; w_miss_id = 3'd6;
        @(negedge clk);
        chk(w_ar_valid == 1 && w_ar_addr == 32'h1234_5670, "R2 wide ar_addr", w_ar_addr, 32'h1234_5670);
        chk(w_ar_len == 0, "R10 wide ar_len", w_ar_len, 0);
        chk(w_ar_size == 3'd4 && w_ar_burst == 2'b01, "R2 wide size/burst", {w_ar_size, w_ar_burst}, {3'd4, 2'b01});
        chk(w_miss_ready == 0, "R3 wide limit one", w_miss_ready, 0);
        @(posedge clk); #1 w_ar_ready = 1;
        @(posedge clk); #1 w_ar_ready = 0;
        w_r_valid = 1; w_r_last = 1; w_r_data = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        @(negedge clk);
        chk(w_miss_ready == 0, "R3 wide still open", w_miss_ready, 0);
        @(posedge clk); #1 w_r_valid = 0;
        @(negedge clk);
        chk(w_out_valid == 1 && w_out_data == 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
            "R10 wide single beat", w_out_data, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        chk(w_out_id == 3'd5 && w_out_last == 1 && w_out_pf == 0, "R10 wide tag/last",
            {w_out_id, w_out_last, w_out_pf}, {3'd5, 1'b1, 1'b0});
        chk(w_miss_ready == 1, "R3 wide slot freed", w_miss_ready, 1);
        @(posedge clk); #1 w_miss_valid = 0;
        @(negedge clk);
        chk(w_ar_valid == 1 && w_ar_addr == 32'h2000_0040, "R2 wide second addr", w_ar_addr, 32'h2000_0040);
        @(posedge clk); #1 w_ar_ready = 1;
        @(posedge clk); #1 w_ar_ready = 0;
        w_r_valid = 1; w_r_last = 0; w_r_data = 128'h55;
        @(negedge clk);
        chk(w_err == 0, "R7 wide no error yet", w_err, 0);
        @(posedge clk); #1 w_r_valid = 0;
        @(negedge clk);
        chk(w_out_valid == 1 && w_out_id == 3'd6, "R5 wide second tag", w_out_id, 3'd6);
        chk(w_err == 1, "R7 wrong last flag", w_err, 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule